// File: doc/BRIEF.md
# Lowest-Priority Interrupt Target Arbiter

This block chooses which processor agents receive an inter-processor interrupt request. A request strobe arrives with the sender's agent number, a two-bit shorthand code, a delivery mode and a logical destination mask. Alongside it come, for every agent, its task priority, its highest in-service vector and its highest pending vector. From those three values the block derives an 8-bit arbitration priority for each agent. It then forms the candidate set from the shorthand or from the mask.

In fixed mode, every candidate is targeted at once. In lowest-priority mode, only the candidate with the smallest arbitration priority is targeted. The result is registered, so the target vector and its valid strobe appear one clock after the request, and a new request can be taken every cycle. The per-agent arbitration priorities are also exposed as 32-bit words for software to read. Each word is refreshed only when a request is taken.

Top module: `ipi_lp_arbiter`

## Requirements
- R1: When an agent's task-priority class (bits 7:4) is greater than or equal to its pending class and strictly greater than its in-service class, its arbitration priority equals the full 8-bit task priority.
- R2: Otherwise, the upper nibble of the arbitration priority is the larger of (task class AND in-service class) and the pending class, and the lower nibble is zero.
- R3: Each agent's priority word is 32 bits wide, with bits 31:8 always zero. It is zero after reset, is loaded only in a cycle with a request, and holds its value otherwise.
- R4: The shorthand code selects the candidates: 2'b00 uses the logical mask, 2'b01 selects only the sender, 2'b10 selects every agent except the sender, and 2'b11 selects every agent.
- R5: When the shorthand code is non-zero, the logical mask has no effect on the result.
- R6: With lowest_mode_i = 1 and a non-empty candidate set, exactly one target bit is set: the one for the candidate with the smallest arbitration priority.
- R7: Among candidates that share the smallest arbitration priority, the one with the lowest agent number wins.
- R8: With lowest_mode_i = 0, the target vector equals the candidate set, with no arbitration.
- R9: An empty candidate set still produces valid, with an all-zero target vector and the no-target flag high for that one cycle.
- R10: Valid, targets and the flag appear exactly one clock after the request. Requests on consecutive cycles each produce a result. In cycles without a result, all three are zero.
- R11: The result uses the priority inputs present in the request cycle. Changes to those inputs afterwards do not alter the result or the stored priority words.
- R12: While in reset, valid, the target vector, the flag and all priority words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe |
| src_id_i | input | ID_W | Sending agent number |
| shorthand_i | input | 2 | Destination shorthand code |
| lowest_mode_i | input | 1 | 1 = lowest-priority delivery, 0 = fixed delivery |
| dest_mask_i | input | NUM_AGENTS | Logical destination mask, one bit per agent |
| task_prio_i | input | NUM_AGENTS*8 | Task priority per agent, agent i at bits 8i+7:8i |
| isr_vec_i | input | NUM_AGENTS*8 | Highest in-service vector per agent |
| irr_vec_i | input | NUM_AGENTS*8 | Highest pending vector per agent |
| tgt_o | output | NUM_AGENTS | Target vector |
| tgt_valid_o | output | 1 | Result valid strobe |
| no_tgt_o | output | 1 | Empty candidate set flag |
| apr_word_o | output | NUM_AGENTS*32 | Arbitration priority words, agent i at bits 32i+31:32i |

## Verification
On every cycle, the assertions check the following:
- the one-cycle latency, and that outputs stay quiet when no request was taken;
- that at most one target is set in lowest-priority mode;
- the consistency of the no-target flag;
- the decode of the self-only and all-agents shorthands;
- that the priority words hold between requests.

Only the bench's scenarios and its reference model can show the rest. That covers the numeric priority rule in both of its branches, that the winner really has the minimum priority, the tie-break toward the lowest agent number, that the mask is ignored under a shorthand, and that input changes made after a request are not seen.

// File: rtl/ipi_arb_pkg.sv
package ipi_arb_pkg;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_OTHERS = 2'b10,
    SH_ALL    = 2'b11
  } shorthand_e;
endpackage

// File: rtl/ipi_apr_calc.sv
module ipi_apr_calc
  import ipi_arb_pkg::*;
(
  input  logic [PRIO_W-1:0] tpr_i,
  input  logic [PRIO_W-1:0] isr_i,
  input  logic [PRIO_W-1:0] irr_i,
  output logic [PRIO_W-1:0] apr_o
);
  logic [3:0] tcls, scls, rcls, masked;

  always_comb begin
    tcls   = tpr_i[7:4];
    scls   = isr_i[7:4];
    rcls   = irr_i[7:4];
    masked = tcls & scls;
    if ((tcls >= rcls) && (tcls > scls)) begin
      apr_o = tpr_i;
    end else if (masked > rcls) begin
      apr_o = {masked, 4'h0};
    end else begin
      apr_o = {rcls, 4'h0};
    end
  end
endmodule

// File: rtl/ipi_dest_decode.sv
module ipi_dest_decode
  import ipi_arb_pkg::*;
#(
  parameter int unsigned NUM_AGENTS = 4,
  parameter int unsigned ID_W       = 2
) (
  input  logic [ID_W-1:0]       src_id_i,
  input  logic [1:0]            shorthand_i,
  input  logic [NUM_AGENTS-1:0] mask_i,
  output logic [NUM_AGENTS-1:0] cand_o
);
  logic [NUM_AGENTS-1:0] self_vec;

  always_comb begin
    for (int i = 0; i < NUM_AGENTS; i++) begin
      self_vec[i] = (src_id_i == ID_W'(i));
    end
  end

  always_comb begin
    unique case (shorthand_e'(shorthand_i))
      SH_SELF:   cand_o = self_vec;
      SH_OTHERS: cand_o = ~self_vec;
      SH_ALL:    cand_o = '1;
      default:   cand_o = mask_i;
    endcase
  end
endmodule

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick
  import ipi_arb_pkg::*;
#(
  parameter int unsigned NUM_AGENTS = 4
) (
  input  logic [NUM_AGENTS-1:0]             cand_i,
  input  logic [NUM_AGENTS-1:0][PRIO_W-1:0] apr_i,
  output logic [NUM_AGENTS-1:0]             pick_o
);
  logic [PRIO_W-1:0]     best;
  logic                  found;
  logic [NUM_AGENTS-1:0] sel;

  // Linear scan; a strict compare keeps the lowest index on a tie.
  always_comb begin
    best  = '1;
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NUM_AGENTS; i++) begin
      if (cand_i[i] && (!found || (apr_i[i] < best))) begin
        found  = 1'b1;
        best   = apr_i[i];
        sel    = '0;
        sel[i] = 1'b1;
      end
    end
    pick_o = sel;
  end
endmodule

// File: rtl/ipi_lp_arbiter.sv
module ipi_lp_arbiter
  import ipi_arb_pkg::*;
#(
  parameter int unsigned NUM_AGENTS = 4,
  localparam int unsigned ID_W = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_i,
  input  logic [ID_W-1:0]              src_id_i,
  input  logic [1:0]                   shorthand_i,
  input  logic                         lowest_mode_i,
  input  logic [NUM_AGENTS-1:0]        dest_mask_i,
  input  logic [NUM_AGENTS*PRIO_W-1:0] task_prio_i,
  input  logic [NUM_AGENTS*PRIO_W-1:0] isr_vec_i,
  input  logic [NUM_AGENTS*PRIO_W-1:0] irr_vec_i,
  output logic [NUM_AGENTS-1:0]        tgt_o,
  output logic                         tgt_valid_o,
  output logic                         no_tgt_o,
  output logic [NUM_AGENTS*WORD_W-1:0] apr_word_o
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // Per-agent arbitration priority
  logic [NUM_AGENTS-1:0][PRIO_W-1:0] apr_now;

  for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_apr
    ipi_apr_calc u_calc (
      .tpr_i (task_prio_i[g*PRIO_W +: PRIO_W]),
      .isr_i (isr_vec_i[g*PRIO_W +: PRIO_W]),
      .irr_i (irr_vec_i[g*PRIO_W +: PRIO_W]),
      .apr_o (apr_now[g])
    );
  end

  // Candidates and winner
  logic [NUM_AGENTS-1:0] cand, pick;

  ipi_dest_decode #(.NUM_AGENTS(NUM_AGENTS), .ID_W(ID_W)) u_dec (
    .src_id_i    (src_id_i),
    .shorthand_i (shorthand_i),
    .mask_i      (dest_mask_i),
    .cand_o      (cand)
  );

  ipi_lowest_pick #(.NUM_AGENTS(NUM_AGENTS)) u_pick (
    .cand_i (cand),
    .apr_i  (apr_now),
    .pick_o (pick)
  );

  // Next state
  logic [NUM_AGENTS-1:0]             tgt_d, tgt_q;
  logic                              valid_d, valid_q, none_d, none_q, apr_en;
  logic [NUM_AGENTS-1:0][PRIO_W-1:0] apr_q;

  always_comb begin
    valid_d = req_i;
    apr_en  = req_i;
    none_d  = req_i && (cand == '0);
    if (!req_i) begin
      tgt_d = '0;
    end else if (lowest_mode_i) begin
      tgt_d = pick;
    end else begin
      tgt_d = cand;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      none_q  <= 1'b0;
      tgt_q   <= '0;
      apr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      none_q  <= none_d;
      tgt_q   <= tgt_d;
      if (apr_en) begin
        apr_q <= apr_now;
      end
    end
  end

  assign tgt_o       = tgt_q;
  assign tgt_valid_o = valid_q;
  assign no_tgt_o    = none_q;

  for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_word
    assign apr_word_o[g*WORD_W +: WORD_W] = {{(WORD_W-PRIO_W){1'b0}}, apr_q[g]};
  end
endmodule

// File: rtl/ipi_arb_checker.sv
module ipi_arb_checker
  import ipi_arb_pkg::*;
#(
  parameter int unsigned NUM_AGENTS = 4,
  parameter int unsigned ID_W       = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_i,
  input logic [ID_W-1:0]              src_id_i,
  input logic [1:0]                   shorthand_i,
  input logic                         lowest_mode_i,
  input logic [NUM_AGENTS-1:0]        tgt_o,
  input logic                         tgt_valid_o,
  input logic                         no_tgt_o,
  input logic [NUM_AGENTS*WORD_W-1:0] apr_word_o
);
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> tgt_valid_o);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!tgt_valid_o && (tgt_o == '0) && !no_tgt_o));

  p_single_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && lowest_mode_i) |=> $onehot0(tgt_o));

  p_empty_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    no_tgt_o |-> (tgt_valid_o && (tgt_o == '0)));

  p_self_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && (shorthand_i == 2'b01) && (int'(src_id_i) < NUM_AGENTS))
      |=> (tgt_o == (NUM_AGENTS'(1) << $past(src_id_i))));

  p_all_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && (shorthand_i == 2'b11) && !lowest_mode_i) |=> (tgt_o == '1));

  p_apr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(apr_word_o));
endmodule

bind ipi_lp_arbiter ipi_arb_checker #(.NUM_AGENTS(NUM_AGENTS), .ID_W(ID_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .req_i         (req_i),
  .src_id_i      (src_id_i),
  .shorthand_i   (shorthand_i),
  .lowest_mode_i (lowest_mode_i),
  .tgt_o         (tgt_o),
  .tgt_valid_o   (tgt_valid_o),
  .no_tgt_o      (no_tgt_o),
  .apr_word_o    (apr_word_o)
);

// File: tb/sim_ipi_lp_arbiter.sv
module sim_ipi_lp_arbiter;
  localparam int N = 4;
  localparam int IDW = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           req;
  logic [IDW-1:0] src;
  logic [1:0]     sh;
  logic           lowest;
  logic [N-1:0]   mask;
  logic [7:0]     tpr_b [N];
  logic [7:0]     isr_b [N];
  logic [7:0]     irr_b [N];
  logic [N*8-1:0] tpr_bus, isr_bus, irr_bus;
  logic [N-1:0]   tgt;
  logic           valid, none;
  logic [N*32-1:0] words;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      tpr_bus[i*8 +: 8] = tpr_b[i];
      isr_bus[i*8 +: 8] = isr_b[i];
      irr_bus[i*8 +: 8] = irr_b[i];
    end
  end

  ipi_lp_arbiter #(.NUM_AGENTS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .src_id_i(src), .shorthand_i(sh),
    .lowest_mode_i(lowest), .dest_mask_i(mask), .task_prio_i(tpr_bus),
    .isr_vec_i(isr_bus), .irr_vec_i(irr_bus), .tgt_o(tgt), .tgt_valid_o(valid),
    .no_tgt_o(none), .apr_word_o(words)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int exp_apr [N];
  int exp_tgt, exp_valid, exp_none;

  function automatic int ref_apr(int t, int s, int r);
    int tc = t / 16;
    int sc = s / 16;
    int rc = r / 16;
    int m;
    if (tc >= rc && tc > sc) return t;
    m = tc & sc;
    return ((m > rc) ? m : rc) * 16;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "valid", int'(valid), exp_valid);
    chk(tag, "target", int'(tgt), exp_tgt);
    chk(tag, "no_target", int'(none), exp_none);
    for (int i = 0; i < N; i++) chk(tag, "apr_word", int'(words[i*32 +: 32]), exp_apr[i]);
  endtask

  // One clock: model the request on the current inputs, then compare.
  task automatic cycle(string tag);
    int cset = 0;
    int best = 1000;
    int win = 0;
    if (req) begin
      for (int i = 0; i < N; i++) begin
        bit c;
        case (sh)
          2'd0: c = mask[i];
          2'd1: c = (i == int'(src));
          2'd2: c = (i != int'(src));
          default: c = 1'b1;
        endcase
        exp_apr[i] = ref_apr(int'(tpr_b[i]), int'(isr_b[i]), int'(irr_b[i]));
        if (c) cset += (1 << i);
      end
      for (int i = 0; i < N; i++) begin
        if (((cset >> i) & 1) == 1 && exp_apr[i] < best) begin
          best = exp_apr[i];
          win = i;
        end
      end
      exp_valid = 1;
      exp_none = (cset == 0);
      exp_tgt = !lowest ? cset : (cset == 0 ? 0 : (1 << win));
    end else begin
      exp_valid = 0;
      exp_none = 0;
      exp_tgt = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic send(string tag, int s, int shc, bit lo, int m);
    req = 1'b1;
    src = IDW'(s);
    sh = 2'(shc);
    lowest = lo;
    mask = N'(m);
    cycle(tag);
  endtask

  task automatic idle(string tag);
    req = 1'b0;
    mask = '1;
    cycle(tag);
  endtask

  task automatic setp(int a, int t, int s, int r);
    tpr_b[a] = 8'(t);
    isr_b[a] = 8'(s);
    irr_b[a] = 8'(r);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req = 0;
    src = 0;
    sh = 0;
    lowest = 0;
    mask = 0;
    for (int i = 0; i < N; i++) begin
      setp(i, 0, 0, 0);
      exp_apr[i] = 0;
    end
    exp_valid = 0;
    exp_tgt = 0;
    exp_none = 0;
    repeat (3) @(negedge clk);
    check_all("R12");
    rst_n = 1'b1;
    repeat (3) idle("R12");

    // R1 / R2 priority rule, lowest-priority winner R6
    setp(0, 8'h53, 8'h40, 8'h50);
    setp(1, 8'h20, 8'h10, 8'h20);
    setp(2, 8'h90, 8'h00, 8'h00);
    setp(3, 8'h44, 8'h44, 8'h00);
    send("R1", 0, 0, 1, 4'b1111);
    send("R6", 0, 0, 1, 4'b1101);
    setp(0, 8'h35, 8'h70, 8'h20);
    setp(1, 8'h6F, 8'h50, 8'h70);
    send("R2", 3, 0, 0, 4'b0011);
    idle("R3");
    // R11: changes after a request are not seen
    send("R11", 1, 0, 1, 4'b0110);
    setp(1, 8'hF0, 8'h00, 8'h00);
    setp(2, 8'h00, 8'h00, 8'h00);
    idle("R11");
    idle("R3");
    // R4 shorthands, R5 mask ignored
    send("R4", 2, 1, 0, 4'b0000);
    send("R4", 2, 2, 0, 4'b0100);
    send("R4", 2, 3, 0, 4'b0000);
    send("R5", 1, 2, 1, 4'b0000);
    send("R5", 3, 3, 1, 4'b0001);
    // R7 ties
    for (int i = 0; i < N; i++) setp(i, 8'h10, 8'h00, 8'h00);
    send("R7", 0, 2, 1, 4'b0000);
    send("R7", 0, 0, 1, 4'b1100);
    // R8 fixed multi-hot
    send("R8", 0, 0, 0, 4'b1010);
    // R9 empty
    send("R9", 0, 0, 1, 4'b0000);
    idle("R9");
    send("R9", 0, 0, 0, 4'b0000);
    // R10 back to back
    send("R10", 1, 0, 0, 4'b0101);
    send("R10", 2, 1, 1, 4'b0000);
    idle("R10");
    // Mixed traffic
    for (int k = 0; k < 400; k++) begin
      for (int i = 0; i < N; i++) setp(i, $urandom % 256, $urandom % 256, $urandom % 256);
      if ($urandom % 4 == 0) idle("R10");
      else send("R6", $urandom % N, $urandom % 4, $urandom % 2, $urandom % 16);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule